// File: doc/BRIEF.md
# Quadrature Subcarrier Phase Generator

This block takes a clock running at four times the colour subcarrier frequency and divides it down into two square-wave references in quadrature, one for the U modulator and one for the V modulator. A 2-bit phase index is also brought out so downstream logic can see where the divider is. The U reference sits at 0° and the V reference sits at 90°. With the default clock rates the resulting subcarrier is 3.579545 MHz for the 525-line standard and 4.43361875 MHz for the 625-line standard.

When the standard select is low (PAL), the V reference is inverted on each successive line. It swings between 90° and 270°, and a line strobe from the sync classifier advances this alternation. When the standard select is high (NTSC), V stays at 90°. A frame strobe can clear the divider and the line alternation. A spacing select picks whether this clear happens on every frame strobe or only on every fourth one. When sync and clock are locked together, a clear that lands where the divider would wrap anyway changes nothing in the output sequence.

Top module: `subcarrier_quad_gen`

## Requirements
- R1: While `rst_n` is low, `phase_idx` is 0, `u_ref` is 1 and `v_ref` is 0. With no clearing strobe, `phase_idx` advances by one on every clock and wraps from 3 to 0.
- R2: `u_ref` is 1 when `phase_idx` is 0 or 1 and 0 when it is 2 or 3. With the line toggle clear, `v_ref` is 1 when `phase_idx` is 1 or 2 and 0 when it is 0 or 3. When the toggle is set, `v_ref` is the inverse of that (270°).
- R3: With `std_ntsc` high and the toggle clear, line strobes leave `v_ref` at the 90° pattern.
- R4: With `std_ntsc` low, each line strobe that does not coincide with a divider clear flips the line toggle. The flip takes effect from the next clock.
- R5: With `clear_each_frame` high, a frame strobe makes `phase_idx` 0 on the following clock.
- R6: With `clear_each_frame` low, a frame strobe clears the divider only when it is the 4th, 8th, 12th... frame strobe counted since reset. The count includes strobes seen while `clear_each_frame` was high. Other strobes leave the count advancing.
- R7: A divider clear that arrives when `phase_idx` is 3 leaves the output sequence exactly as free running would give it.
- R8: A divider clear also clears the line toggle, so the next line uses +90°.
- R9: On switching `std_ntsc` high with the toggle set, `v_ref` stays inverted until the next line strobe, and that strobe clears the toggle.
- R10: When a line strobe and a divider clear land in the same cycle, the toggle ends up clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at four times the subcarrier frequency |
| rst_n | input | 1 | Asynchronous reset, active low |
| std_ntsc | input | 1 | 1 selects NTSC (fixed V phase), 0 selects PAL (line-alternating V) |
| clear_each_frame | input | 1 | 1 clears on every frame strobe, 0 on every fourth |
| line_stb | input | 1 | One-cycle pulse at each valid line sync |
| frame_stb | input | 1 | One-cycle pulse at each frame boundary |
| phase_idx | output | DIV_W (2) | Divider count, 0 is the 0° phase |
| u_ref | output | 1 | U-axis square-wave reference, 0° |
| v_ref | output | 1 | V-axis square-wave reference, 90° or 270° |

## Verification
The assertions take the strobes to be single-cycle pulses that are synchronous to the subcarrier clock. They also take `std_ntsc` and `clear_each_frame` to be sampled only on the clock edge, so no input is checked against events between edges. The stimulus changes every input on the falling clock edge, and each strobe is held for exactly one cycle. Frame strobes are placed at chosen divider counts, including the wrap count 3 and the coincidence of a line strobe with a clear. The bench model counts frame strobes from reset, in the same way as the block, so the fourth-frame spacing is predicted and not tuned after the fact.

// File: rtl/sqg_pkg.sv
package sqg_pkg;

   typedef enum logic {
      STD_PAL  = 1'b0,
      STD_NTSC = 1'b1
   } tv_std_e;

   typedef struct packed {
      logic u;
      logic v;
   } ref_pair_t;

endpackage

// File: rtl/sqg_divider.sv
module sqg_divider #(
   parameter int DIV_W   = 2,
   parameter int FRAME_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_stb,
   input  logic             every_frame,
   output logic [DIV_W-1:0] cnt,
   output logic             frame_clr
);

   localparam logic [FRAME_W-1:0] FRAME_LAST = {FRAME_W{1'b1}};

   generate
      if (DIV_W < 2) begin : g_bad_div
         $error("sqg_divider: DIV_W must be at least 2");
      end
      if (FRAME_W < 1) begin : g_bad_frame
         $error("sqg_divider: FRAME_W must be at least 1");
      end
   endgenerate

   logic [FRAME_W-1:0] frame_cnt;

   always_comb begin
      frame_clr = frame_stb && (every_frame || (frame_cnt == FRAME_LAST));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt       <= '0;
         frame_cnt <= '0;
      end else begin
         if (frame_stb) begin
            frame_cnt <= frame_cnt + 1'b1;
         end
         if (frame_clr) begin
            cnt <= '0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   logic past_ok;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !$past(frame_clr)) |-> (cnt == DIV_W'($past(cnt) + 1'b1)));

   assert_clear_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(frame_clr)) |-> (cnt == '0));

   assert_skip_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(frame_stb && !every_frame && (frame_cnt != FRAME_LAST)))
      |-> (cnt == DIV_W'($past(cnt) + 1'b1)));

endmodule

// File: rtl/sqg_line_alt.sv
module sqg_line_alt
   import sqg_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  tv_std_e std_sel,
   input  logic    line_stb,
   input  logic    frame_clr,
   output logic    alt
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alt <= 1'b0;
      end else if (frame_clr) begin
         alt <= 1'b0;
      end else if (line_stb) begin
         alt <= (std_sel == STD_PAL) ? ~alt : 1'b0;
      end
   end

   logic past_ok;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   assert_pal_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(line_stb && !frame_clr && (std_sel == STD_PAL)))
      |-> (alt != $past(alt)));

   assert_clear_toggle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(frame_clr)) |-> !alt);

   assert_ntsc_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(line_stb && (std_sel == STD_NTSC))) |-> !alt);

   assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(!line_stb && !frame_clr)) |-> $stable(alt));

endmodule

// File: rtl/sqg_phase_map.sv
module sqg_phase_map
   import sqg_pkg::*;
#(
   parameter int DIV_W   = 2,
   parameter bit REG_OUT = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] cnt,
   input  logic             alt,
   output logic [DIV_W-1:0] idx_o,
   output logic             u_o,
   output logic             v_o
);

   localparam logic [DIV_W-1:0] HALF_L    = DIV_W'(2 ** (DIV_W - 1));
   localparam logic [DIV_W-1:0] QUARTER_L = DIV_W'(2 ** (DIV_W - 2));

   logic [DIV_W-1:0] lagged;
   ref_pair_t        pair_c;

   always_comb begin
      lagged   = cnt - QUARTER_L;
      pair_c.u = (cnt < HALF_L);
      pair_c.v = (lagged < HALF_L) ^ alt;
   end

   generate
      if (REG_OUT) begin : g_reg
         logic [DIV_W-1:0] idx_q;
         ref_pair_t        pair_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               idx_q  <= '0;
               pair_q <= '{u: 1'b1, v: 1'b0};
            end else begin
               idx_q  <= cnt;
               pair_q <= pair_c;
            end
         end
         assign idx_o = idx_q;
         assign u_o   = pair_q.u;
         assign v_o   = pair_q.v;
      end else begin : g_comb
         assign idx_o = cnt;
         assign u_o   = pair_c.u;
         assign v_o   = pair_c.v;
      end
   endgenerate

   assert_u_lead_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (idx_o == '0) |-> u_o);

   assert_u_trail_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (idx_o == HALF_L) |-> !u_o);

endmodule

// File: rtl/subcarrier_quad_gen.sv
module subcarrier_quad_gen
   import sqg_pkg::*;
#(
   parameter int DIV_W   = 2,
   parameter int FRAME_W = 2,
   parameter bit REG_OUT = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             std_ntsc,
   input  logic             clear_each_frame,
   input  logic             line_stb,
   input  logic             frame_stb,
   output logic [DIV_W-1:0] phase_idx,
   output logic             u_ref,
   output logic             v_ref
);

   logic [DIV_W-1:0] div_cnt;
   logic             div_clr;
   logic             line_alt;
   tv_std_e          std_sel;

   assign std_sel = tv_std_e'(std_ntsc);

   sqg_divider #(
      .DIV_W   (DIV_W),
      .FRAME_W (FRAME_W)
   ) u_div (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_stb   (frame_stb),
      .every_frame (clear_each_frame),
      .cnt         (div_cnt),
      .frame_clr   (div_clr)
   );

   sqg_line_alt u_alt (
      .clk       (clk),
      .rst_n     (rst_n),
      .std_sel   (std_sel),
      .line_stb  (line_stb),
      .frame_clr (div_clr),
      .alt       (line_alt)
   );

   sqg_phase_map #(
      .DIV_W   (DIV_W),
      .REG_OUT (REG_OUT)
   ) u_map (
      .clk   (clk),
      .rst_n (rst_n),
      .cnt   (div_cnt),
      .alt   (line_alt),
      .idx_o (phase_idx),
      .u_o   (u_ref),
      .v_o   (v_ref)
   );

   assert_same_line_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n && line_stb && div_clr) |-> (v_ref == ((phase_idx == 2'd1) || (phase_idx == 2'd2))));

endmodule

// File: tb/subcarrier_quad_gen_bench.sv
`timescale 1ns/1ps
module subcarrier_quad_gen_bench;

   typedef struct {
      string      tag;
      logic [1:0] idx;
      logic       u;
      logic       v;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       std_ntsc = 1'b1;
   logic       clear_each_frame = 1'b1;
   logic       line_stb = 1'b0;
   logic       frame_stb = 1'b0;
   logic [1:0] phase_idx;
   logic       u_ref;
   logic       v_ref;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   exp_t q[$];

   // bench model state
   logic [1:0] m_cnt = 2'd0;
   logic [1:0] m_frames = 2'd0;
   logic       m_alt = 1'b0;

   always #10 clk = ~clk;

   subcarrier_quad_gen u_subcarrier_quad_gen (
      .clk              (clk),
      .rst_n            (rst_n),
      .std_ntsc         (std_ntsc),
      .clear_each_frame (clear_each_frame),
      .line_stb         (line_stb),
      .frame_stb        (frame_stb),
      .phase_idx        (phase_idx),
      .u_ref            (u_ref),
      .v_ref            (v_ref)
   );

   function automatic logic u_of(input logic [1:0] c);
      return (c == 2'd0) || (c == 2'd1);
   endfunction

   function automatic logic v90_of(input logic [1:0] c);
      return (c == 2'd1) || (c == 2'd2);
   endfunction

   // driver: applies one cycle of stimulus at the falling edge, predicts, pushes
   task automatic step(input logic ls, input logic fs, input logic ntsc,
                       input logic every, input string tag);
      logic clr;
      exp_t e;
      line_stb         = ls;
      frame_stb        = fs;
      std_ntsc         = ntsc;
      clear_each_frame = every;
      clr = fs && (every || (m_frames == 2'd3));
      if (fs) m_frames = m_frames + 2'd1;
      m_cnt = clr ? 2'd0 : m_cnt + 2'd1;
      if (clr)     m_alt = 1'b0;
      else if (ls) m_alt = ntsc ? 1'b0 : ~m_alt;
      e.tag = tag;
      e.idx = m_cnt;
      e.u   = u_of(m_cnt);
      e.v   = v90_of(m_cnt) ^ m_alt;
      q.push_back(e);
      @(negedge clk);
   endtask

   task automatic idle_until(input logic [1:0] c, input logic ntsc,
                             input logic every, input string tag);
      while (m_cnt != c) step(1'b0, 1'b0, ntsc, every, tag);
   endtask

   // monitor: samples between the rising and falling edge
   initial begin
      forever begin
         @(posedge clk);
         #5;
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (phase_idx !== e.idx || u_ref !== e.u || v_ref !== e.v) begin
               errors++;
               $display("FAIL %s: got idx=%0d u=%0b v=%0b expected idx=%0d u=%0b v=%0b",
                        e.tag, phase_idx, u_ref, v_ref, e.idx, e.u, e.v);
            end
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      checks++;
      if (phase_idx !== 2'd0 || u_ref !== 1'b1 || v_ref !== 1'b0) begin
         errors++;
         $display("FAIL R1 reset: got idx=%0d u=%0b v=%0b expected idx=0 u=1 v=0",
                  phase_idx, u_ref, v_ref);
      end
      rst_n = 1'b1;

      // R1 R2: free run, standard fixed
      for (int i = 0; i < 8; i++) step(1'b0, 1'b0, 1'b1, 1'b1, "R1 R2 free run");

      // R3: line strobes under NTSC leave V at 90 degrees
      for (int i = 0; i < 9; i++) step((i % 3) == 0, 1'b0, 1'b1, 1'b1, "R3 ntsc lines");

      // R4: PAL alternation
      for (int i = 0; i < 10; i++) step((i % 2) == 0, 1'b0, 1'b0, 1'b1, "R4 pal lines");

      // R5: every-frame clear at count 1
      idle_until(2'd1, 1'b1, 1'b1, "R5 align");
      step(1'b0, 1'b1, 1'b1, 1'b1, "R5 clear");
      for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b1, 1'b1, "R5 after clear");

      // R6: fourth-frame spacing, strobes placed at count 1
      for (int k = 0; k < 5; k++) begin
         idle_until(2'd1, 1'b1, 1'b0, "R6 align");
         step(1'b0, 1'b1, 1'b1, 1'b0, "R6 spaced strobe");
         for (int i = 0; i < 2; i++) step(1'b0, 1'b0, 1'b1, 1'b0, "R6 after strobe");
      end

      // R7: clear at the wrap count is transparent
      idle_until(2'd3, 1'b1, 1'b1, "R7 align");
      step(1'b0, 1'b1, 1'b1, 1'b1, "R7 clear at wrap");
      for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 1'b1, 1'b1, "R7 sequence");

      // R8: clear resets the PAL toggle
      if (m_alt == 1'b0) step(1'b1, 1'b0, 1'b0, 1'b1, "R8 set toggle");
      for (int i = 0; i < 2; i++) step(1'b0, 1'b0, 1'b0, 1'b1, "R8 toggled");
      step(1'b0, 1'b1, 1'b0, 1'b1, "R8 clear");
      for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b0, 1'b1, "R8 after clear");

      // R9: switch to NTSC with toggle set, held until next line strobe
      step(1'b1, 1'b0, 1'b0, 1'b1, "R9 set toggle");
      for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 1'b1, 1'b1, "R9 held inverted");
      step(1'b1, 1'b0, 1'b1, 1'b1, "R9 ntsc strobe");
      for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b1, 1'b1, "R9 after strobe");

      // R10: line strobe and clear in the same cycle, toggle clear and set
      step(1'b1, 1'b1, 1'b0, 1'b1, "R10 both toggle clear");
      for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b0, 1'b1, "R10 after");
      step(1'b1, 1'b0, 1'b0, 1'b1, "R10 set toggle");
      step(1'b1, 1'b1, 1'b0, 1'b1, "R10 both toggle set");
      for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b0, 1'b1, "R10 after");

      line_stb  = 1'b0;
      frame_stb = 1'b0;
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got running expected finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule